// File: doc/BRIEF.md
# Flash Program/Erase Status Word Responder

This block stands in for the status side of a NOR-style flash while an internal program or erase job runs. It follows which job is under way: idle, program, sector erase, erase suspended, or program inside an erase suspend. It also keeps one "chosen for erase" bit per sector. On every read strobe it returns, one clock later, either the status word or array data. The choice depends on the current job and on whether the read address falls in a chosen sector. Array data comes from a fixed address-derived stub.

The status word carries two toggle bits, a fault bit and an erase-started bit. A controller polls it to learn whether a job is still running, which sectors are being erased, and whether the job overran its pulse budget. Commands arrive on a single strobed opcode port. Program, erase and fault-clear all go through that same port.

Top module: `flash_status_resp`

## Requirements
- R1: After reset the mode is idle (mode_o = 0) and rd_valid and rd_data are 0. Every read strobe gives rd_valid = 1 on the next cycle and only then. With no job pending, rd_data is array data: bit i equals rd_addr[i mod ADDR_W] XOR STUB_KEY[i].
- R2: The status word is 0 except for these bits. Bit 6 is the main toggle bit. Bit 5 is the fault bit. Bit 3 is the erase-started bit. Bit 2 is the sector toggle bit. While programming (mode 1), bit 6 inverts on each status read at any address and bit 2 stays fixed.
- R3: While erasing (mode 2) after the window, a read in a chosen sector inverts both bit 6 and bit 2. A read in an unchosen sector inverts bit 6 only. The sector is the top log2(NSEC) address bits.
- R4: In erase suspend (mode 3), a read in a chosen sector holds bit 6 and inverts bit 2. A read in an unchosen sector returns array data.
- R5: While programming inside a suspend (mode 4), bit 6 inverts at any address and bit 2 stays fixed.
- R6: Both toggle bits return to 0 when a job starts. Each read returns the value held before that read inverts it, so the first status read of a new job shows 0 in bits 6 and 2.
- R7: A sector erase (op 2) opens an acceptance window of WIN_LEN cycles, during which bit 3 reads 0. A further sector erase inside the window adds that sector and restarts the full window. Bit 3 reads 1 once the window has closed and the erase is pending.
- R8: A chip erase (op 3) from idle chooses every sector and opens no window, so bit 3 reads 1 on the first read.
- R9: A program issued with cmd_raise = 1 (a request to turn a 0 bit back to 1) never completes. Bit 5 goes to 1 after PULSE_LIMIT busy cycles, and the mode is held.
- R10: A fault_in pulse during an active program, or during an erase after its window, sets bit 5 and freezes the job.
- R11: A reset command (op 6) clears a fault. From mode 1 or mode 2 it returns to idle, and from mode 4 it returns to mode 3.
- R12: A program completes after BUSY_LEN cycles, and an erase completes BUSY_LEN cycles after its window closes. A program from idle returns to mode 0. A program inside a suspend returns to mode 3. A finished erase clears all sector choices.
- R13: Commands that do not apply to the current mode are ignored. This includes reset with no fault, suspend (op 4) during the window, and fault_in while idle. Resume is op 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command opcode |
| cmd_sector | input | log2(NSEC) | Sector for sector erase |
| cmd_raise | input | 1 | Program asks to raise a 0 bit to 1 |
| fault_in | input | 1 | External pulse-limit fault pulse |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address, sector in top bits |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | DATA_W | Status word or array data |
| mode_o | output | 3 | Current job mode |

## Verification
The embedded properties check several things on every cycle:
- the acceptance window is open only while erasing;
- idle never holds a fault or a sector choice;
- any erase-related mode holds at least one choice, and a chip erase chooses all;
- a fault is cleared only by a reset command;
- rd_valid tracks the strobe;
- bit 2 never moves while programming, and bit 6 never moves while suspended.

The per-mode and per-sector toggle matrix, the exact cycle at which the window closes after a restart, the completion and pulse-limit cycle counts, and the places each reset command returns to can only be shown by the bench's scenarios.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  typedef enum logic [2:0] {
    M_IDLE  = 3'd0,
    M_PROG  = 3'd1,
    M_ERASE = 3'd2,
    M_SUSP  = 3'd3,
    M_SPROG = 3'd4
  } mode_e;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_PROG   = 3'd1,
    OP_SERASE = 3'd2,
    OP_CERASE = 3'd3,
    OP_SUSP   = 3'd4,
    OP_RESUME = 3'd5,
    OP_RESET  = 3'd6,
    OP_RSVD   = 3'd7
  } op_e;

  localparam int BIT_TOG_MAIN = 6;
  localparam int BIT_FAULT    = 5;
  localparam int BIT_ERASE_GO = 3;
  localparam int BIT_TOG_SEC  = 2;
endpackage

// File: rtl/fsr_array_stub.sv
module fsr_array_stub #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] STUB_KEY = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);
  // Address bits folded over the word and scrambled by a fixed key.
  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      data[i] = addr[i % ADDR_W] ^ STUB_KEY[i];
    end
  end
endmodule

// File: rtl/fsr_ctrl.sv
module fsr_ctrl
  import fsr_pkg::*;
#(
  parameter int NSEC        = 8,
  parameter int BUSY_LEN    = 64,
  parameter int PULSE_LIMIT = 256,
  parameter int WIN_LEN     = 32,
  localparam int SEC_W = $clog2(NSEC),
  localparam int CNT_MAX = (PULSE_LIMIT > BUSY_LEN) ? PULSE_LIMIT : BUSY_LEN,
  localparam int CNT_W = $clog2(CNT_MAX + 1),
  localparam int WIN_W = $clog2(WIN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [SEC_W-1:0] cmd_sector,
  input  logic             cmd_raise,
  input  logic             fault_in,
  output mode_e            mode,
  output logic [NSEC-1:0]  sel_mask,
  output logic             fault,
  output logic             erase_go,
  output logic             op_start
);
  op_e op;
  assign op = op_e'(cmd_op);

  logic             window;
  logic [WIN_W-1:0] wcnt;
  logic [CNT_W-1:0] pcnt, ecnt;
  logic             raise_q;
  mode_e            mode_n;

  logic start_prog, start_serase, add_serase, start_cerase;
  logic do_susp, do_resume, do_reset;
  logic prog_active, erase_active, prog_done, erase_done, fault_set;

  assign start_prog   = cmd_valid && op == OP_PROG && (mode == M_IDLE || mode == M_SUSP);
  assign start_serase = cmd_valid && op == OP_SERASE && mode == M_IDLE;
  assign add_serase   = cmd_valid && op == OP_SERASE && mode == M_ERASE && window;
  assign start_cerase = cmd_valid && op == OP_CERASE && mode == M_IDLE;
  assign do_susp      = cmd_valid && op == OP_SUSP && mode == M_ERASE && !window && !fault;
  assign do_resume    = cmd_valid && op == OP_RESUME && mode == M_SUSP;
  assign do_reset     = cmd_valid && op == OP_RESET && fault;
  assign op_start     = start_prog || start_serase || start_cerase;

  assign prog_active  = (mode == M_PROG || mode == M_SPROG) && !fault;
  assign erase_active = mode == M_ERASE && !window && !fault;
  assign prog_done    = prog_active && !raise_q && !fault_in && pcnt == CNT_W'(BUSY_LEN - 1);
  assign erase_done   = erase_active && !fault_in && ecnt == CNT_W'(BUSY_LEN - 1);
  assign fault_set    = (prog_active && !prog_done &&
                         (fault_in || pcnt == CNT_W'(PULSE_LIMIT - 1))) ||
                        (erase_active && fault_in);
  assign erase_go     = (mode == M_ERASE || mode == M_SUSP || mode == M_SPROG) && !window;

  always_comb begin
    mode_n = mode;
    unique case (mode)
      M_IDLE:  if (start_prog) mode_n = M_PROG;
               else if (start_serase || start_cerase) mode_n = M_ERASE;
      M_PROG:  if (do_reset || prog_done) mode_n = M_IDLE;
      M_ERASE: if (do_reset || erase_done) mode_n = M_IDLE;
               else if (do_susp) mode_n = M_SUSP;
      M_SUSP:  if (do_resume) mode_n = M_ERASE;
               else if (start_prog) mode_n = M_SPROG;
      M_SPROG: if (do_reset || prog_done) mode_n = M_SUSP;
      default: mode_n = M_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode     <= M_IDLE;
      sel_mask <= '0;
      fault    <= 1'b0;
      window   <= 1'b0;
      wcnt     <= '0;
      pcnt     <= '0;
      ecnt     <= '0;
      raise_q  <= 1'b0;
    end else begin
      mode <= mode_n;

      if (do_reset) fault <= 1'b0;
      else if (fault_set) fault <= 1'b1;

      if (start_prog) begin
        pcnt    <= '0;
        raise_q <= cmd_raise;
      end else if (prog_active && !prog_done && !fault_set) begin
        pcnt <= pcnt + 1'b1;
      end

      if (start_serase || start_cerase) ecnt <= '0;
      else if (erase_active && !erase_done && !fault_set) ecnt <= ecnt + 1'b1;

      if (start_serase || add_serase) begin
        window <= 1'b1;
        wcnt   <= '0;
      end else if (start_cerase) begin
        window <= 1'b0;
      end else if (window) begin
        if (wcnt == WIN_W'(WIN_LEN - 1)) window <= 1'b0;
        else wcnt <= wcnt + 1'b1;
      end

      if (start_serase) sel_mask <= NSEC'(1) << cmd_sector;
      else if (add_serase) sel_mask <= sel_mask | (NSEC'(1) << cmd_sector);
      else if (start_cerase) sel_mask <= '1;
      else if (mode == M_ERASE && mode_n == M_IDLE) sel_mask <= '0;
    end
  end

  // R7: acceptance window only exists inside an erase
  p_window_in_erase_r7: assert property (@(posedge clk) disable iff (rst)
    window |-> mode == M_ERASE);
  // R12: idle carries no sector choice and no fault
  p_idle_clean_r12: assert property (@(posedge clk) disable iff (rst)
    mode == M_IDLE |-> (sel_mask == '0 && !fault));
  // R8: erase-related modes always have at least one chosen sector
  p_erase_has_sel_r8: assert property (@(posedge clk) disable iff (rst)
    (mode == M_ERASE || mode == M_SUSP || mode == M_SPROG) |-> sel_mask != '0);
  // R8: chip erase chooses every sector
  p_chip_all_r8: assert property (@(posedge clk) disable iff (rst)
    start_cerase |=> &sel_mask);
  // R11: fault drops only after a reset command
  p_fault_clear_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(fault) |-> $past(cmd_valid && op == OP_RESET));
endmodule

// File: rtl/fsr_rdpath.sv
module fsr_rdpath
  import fsr_pkg::*;
#(
  parameter int NSEC   = 8,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  localparam int SEC_W = $clog2(NSEC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  mode_e             mode,
  input  logic [NSEC-1:0]   sel_mask,
  input  logic              fault,
  input  logic              erase_go,
  input  logic              op_start,
  input  logic [DATA_W-1:0] arr_data,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic [SEC_W-1:0]  sec;
  logic              sel, status_rd, flip_main, flip_sec;
  logic              tog_main, tog_sec;
  logic [DATA_W-1:0] stat;

  assign sec       = rd_addr[ADDR_W-1 -: SEC_W];
  assign sel       = sel_mask[sec];
  assign status_rd = rd_en && mode != M_IDLE && !(mode == M_SUSP && !sel);
  assign flip_main = status_rd && (mode == M_PROG || mode == M_ERASE || mode == M_SPROG);
  assign flip_sec  = status_rd && sel && (mode == M_ERASE || mode == M_SUSP);

  always_comb begin
    stat = '0;
    stat[BIT_TOG_MAIN] = tog_main;
    stat[BIT_FAULT]    = fault;
    stat[BIT_ERASE_GO] = erase_go;
    stat[BIT_TOG_SEC]  = tog_sec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      tog_main <= 1'b0;
      tog_sec  <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= status_rd ? stat : arr_data;
      if (op_start) begin
        tog_main <= 1'b0;
        tog_sec  <= 1'b0;
      end else begin
        if (flip_main) tog_main <= ~tog_main;
        if (flip_sec)  tog_sec  <= ~tog_sec;
      end
    end
  end

  // R1: read data is presented exactly one cycle after the strobe
  p_valid_on_r1: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  p_valid_off_r1: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);
  // R2: sector toggle never moves while programming
  p_sec_hold_prog_r2: assert property (@(posedge clk) disable iff (rst)
    mode == M_PROG |=> $stable(tog_sec));
  // R4: main toggle never moves in suspend unless a new job starts
  p_main_hold_susp_r4: assert property (@(posedge clk) disable iff (rst)
    (mode == M_SUSP && !op_start) |=> $stable(tog_main));
endmodule

// File: rtl/flash_status_resp.sv
module flash_status_resp
  import fsr_pkg::*;
#(
  parameter int NSEC        = 8,
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 16,
  parameter int BUSY_LEN    = 64,
  parameter int PULSE_LIMIT = 256,
  parameter int WIN_LEN     = 32,
  parameter logic [DATA_W-1:0] STUB_KEY = 'h5A3C,
  localparam int SEC_W = $clog2(NSEC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [SEC_W-1:0]  cmd_sector,
  input  logic              cmd_raise,
  input  logic              fault_in,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [2:0]        mode_o
);
  mode_e             mode;
  logic [NSEC-1:0]   sel_mask;
  logic              fault, erase_go, op_start;
  logic [DATA_W-1:0] arr_data;

  fsr_ctrl #(
    .NSEC(NSEC), .BUSY_LEN(BUSY_LEN), .PULSE_LIMIT(PULSE_LIMIT), .WIN_LEN(WIN_LEN)
  ) u_ctrl (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_sector(cmd_sector), .cmd_raise(cmd_raise), .fault_in(fault_in),
    .mode(mode), .sel_mask(sel_mask), .fault(fault), .erase_go(erase_go),
    .op_start(op_start)
  );

  fsr_array_stub #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STUB_KEY(STUB_KEY)
  ) u_stub (
    .addr(rd_addr), .data(arr_data)
  );

  fsr_rdpath #(
    .NSEC(NSEC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .mode(mode),
    .sel_mask(sel_mask), .fault(fault), .erase_go(erase_go), .op_start(op_start),
    .arr_data(arr_data), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  assign mode_o = mode;
endmodule

// File: tb/flash_status_resp_tb.sv
module flash_status_resp_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 5;
  localparam int B  = 40;
  localparam int PL = 60;
  localparam logic [7:0] KEY = 8'hC3;

  localparam logic [2:0] C_PROG = 3'd1, C_SER = 3'd2, C_CER = 3'd3,
                         C_SUSP = 3'd4, C_RES = 3'd5, C_RST = 3'd6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [1:0] cmd_sector = '0;
  logic       cmd_raise = 1'b0;
  logic       fault_in = 1'b0;
  logic       rd_en = 1'b0;
  logic [5:0] rd_addr = '0;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic [2:0] mode_o;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_status_resp #(
    .NSEC(4), .ADDR_W(6), .DATA_W(8), .BUSY_LEN(B), .PULSE_LIMIT(PL),
    .WIN_LEN(W), .STUB_KEY(KEY)
  ) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_sector(cmd_sector), .cmd_raise(cmd_raise), .fault_in(fault_in),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .mode_o(mode_o)
  );

  function automatic logic [7:0] arr(input logic [5:0] a);
    return {a[1:0], a} ^ KEY;
  endfunction

  function automatic logic [5:0] adr(input logic [1:0] s);
    return {s, 4'h7};
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic done_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // All tasks start and end at a falling edge and span whole cycles.
  task automatic do_cmd(input logic [2:0] op, input logic [1:0] s, input logic r);
    cmd_valid = 1'b1; cmd_op = op; cmd_sector = s; cmd_raise = r;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_raise = 1'b0; cmd_op = '0;
  endtask

  task automatic do_read(input logic [5:0] a, output logic [7:0] d);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0; d = rd_data;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    wait_cyc(3);
    rst = 1'b0;
  endtask

  task automatic enter(input int sc);
    if (sc == 1) do_cmd(C_PROG, 2'd0, 1'b0);
    if (sc >= 2) begin
      do_cmd(C_SER, 2'd1, 1'b0);
      wait_cyc(W + 2);
    end
    if (sc >= 3) do_cmd(C_SUSP, 2'd0, 1'b0);
    if (sc == 4) do_cmd(C_PROG, 2'd0, 1'b0);
  endtask

  function automatic string sc_tag(input int sc);
    case (sc)
      0: return "R1 idle";
      1: return "R2/R6 program";
      2: return "R3/R6 erase";
      3: return "R4 suspend";
      default: return "R5/R6 suspend-program";
    endcase
  endfunction

  // Toggle matrix: scenario, read sector, array expected, first and second read.
  localparam int NV = 9;
  localparam int         V_SC  [NV] = '{1, 1, 2, 2, 3, 3, 4, 4, 0};
  localparam logic [1:0] V_SEC [NV] = '{2, 0, 1, 3, 1, 0, 3, 1, 2};
  localparam bit         V_ARR [NV] = '{0, 0, 0, 0, 0, 1, 0, 0, 1};
  localparam logic [7:0] V_R1  [NV] = '{8'h00, 8'h00, 8'h08, 8'h08, 8'h08, 8'h00, 8'h08, 8'h08, 8'h00};
  localparam logic [7:0] V_R2  [NV] = '{8'h40, 8'h40, 8'h4C, 8'h48, 8'h0C, 8'h00, 8'h48, 8'h48, 8'h00};

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog expired");
    done_run();
  end

  initial begin
    logic [7:0] d;
    logic [7:0] e1, e2;
    do_reset();

    // R1: reset state
    check("R1 reset mode", {5'd0, mode_o}, 8'd0);
    check("R1 reset valid", {7'd0, rd_valid}, 8'd0);
    check("R1 reset data", rd_data, 8'd0);

    // R1: idle read latency and data
    do_read(6'h2D, d);
    check("R1 valid after strobe", {7'd0, rd_valid}, 8'd1);
    check("R1 idle array data", d, arr(6'h2D));
    @(negedge clk);
    check("R1 valid drops", {7'd0, rd_valid}, 8'd0);

    // Table walk over mode x sector
    for (int k = 0; k < NV; k++) begin
      do_reset();
      enter(V_SC[k]);
      e1 = V_ARR[k] ? arr(adr(V_SEC[k])) : V_R1[k];
      e2 = V_ARR[k] ? arr(adr(V_SEC[k])) : V_R2[k];
      do_read(adr(V_SEC[k]), d);
      check(sc_tag(V_SC[k]), d, e1);
      do_read(adr(V_SEC[k]), d);
      check(sc_tag(V_SC[k]), d, e2);
    end

    // R7: window restart, exact closing cycle
    do_reset();
    do_cmd(C_SER, 2'd1, 1'b0);
    do_read(adr(2'd1), d);
    check("R7 window open", d & 8'h08, 8'h00);
    do_read(adr(2'd1), d);
    do_cmd(C_SER, 2'd2, 1'b0);
    wait_cyc(W - 2);
    do_read(adr(2'd2), d);
    check("R7 window restarted", d & 8'h08, 8'h00);
    do_read(adr(2'd2), d);
    check("R7 last window cycle", d & 8'h08, 8'h00);
    do_read(adr(2'd2), d);
    check("R7 window closed", d & 8'h08, 8'h08);
    do_read(adr(2'd2), d);
    check("R7 added sector chosen", d & 8'h04, 8'h04);

    // R8: chip erase
    do_reset();
    do_cmd(C_CER, 2'd0, 1'b0);
    do_read(adr(2'd3), d);
    check("R8 chip erase first", d, 8'h08);
    do_read(adr(2'd3), d);
    check("R8 chip erase all chosen", d, 8'h4C);

    // R12: program completion cycle
    do_reset();
    do_cmd(C_PROG, 2'd0, 1'b0);
    wait_cyc(B - 1);
    check("R12 program busy", {5'd0, mode_o}, 8'd1);
    @(negedge clk);
    check("R12 program done", {5'd0, mode_o}, 8'd0);

    // R12: erase completion, choices cleared
    do_reset();
    do_cmd(C_SER, 2'd2, 1'b0);
    wait_cyc(W + B - 1);
    check("R12 erase busy", {5'd0, mode_o}, 8'd2);
    @(negedge clk);
    check("R12 erase done", {5'd0, mode_o}, 8'd0);
    do_read(adr(2'd2), d);
    check("R12 choices cleared", d, arr(adr(2'd2)));

    // R12: suspend-program returns to suspend, resume goes back to erase
    do_reset();
    enter(4);
    wait_cyc(B + 1);
    check("R12 suspend-program done", {5'd0, mode_o}, 8'd3);
    do_cmd(C_RES, 2'd0, 1'b0);
    check("R13 resume accepted", {5'd0, mode_o}, 8'd2);

    // R9: pulse limit
    do_reset();
    do_cmd(C_PROG, 2'd0, 1'b1);
    wait_cyc(PL - 2);
    do_read(adr(2'd0), d);
    check("R9 no fault yet", d & 8'h20, 8'h00);
    do_read(adr(2'd0), d);
    check("R9 no fault at limit edge", d & 8'h20, 8'h00);
    do_read(adr(2'd0), d);
    check("R9 fault set", d & 8'h20, 8'h20);
    check("R9 mode held", {5'd0, mode_o}, 8'd1);
    do_cmd(C_RST, 2'd0, 1'b0);
    check("R11 reset to idle", {5'd0, mode_o}, 8'd0);
    do_read(adr(2'd0), d);
    check("R11 array after reset", d, arr(adr(2'd0)));

    // R10: external fault during erase
    do_reset();
    enter(2);
    fault_in = 1'b1;
    @(negedge clk);
    fault_in = 1'b0;
    do_read(adr(2'd1), d);
    check("R10 fault bit", d & 8'h20, 8'h20);
    wait_cyc(B + 5);
    check("R10 erase frozen", {5'd0, mode_o}, 8'd2);
    do_cmd(C_RST, 2'd0, 1'b0);
    do_read(adr(2'd1), d);
    check("R11 erase reset clears", d, arr(adr(2'd1)));

    // R11: fault inside suspend-program returns to suspend
    do_reset();
    enter(3);
    do_cmd(C_PROG, 2'd0, 1'b1);
    wait_cyc(PL + 2);
    do_read(adr(2'd3), d);
    check("R11 suspend-program fault", d & 8'h20, 8'h20);
    do_cmd(C_RST, 2'd0, 1'b0);
    check("R11 back to suspend", {5'd0, mode_o}, 8'd3);

    // R13: inapplicable commands
    do_reset();
    do_cmd(C_PROG, 2'd0, 1'b0);
    do_cmd(C_RST, 2'd0, 1'b0);
    check("R13 reset without fault", {5'd0, mode_o}, 8'd1);
    do_reset();
    do_cmd(C_SER, 2'd0, 1'b0);
    do_cmd(C_SUSP, 2'd0, 1'b0);
    check("R13 suspend in window", {5'd0, mode_o}, 8'd2);
    do_reset();
    fault_in = 1'b1;
    @(negedge clk);
    fault_in = 1'b0;
    do_read(adr(2'd1), d);
    check("R13 idle fault ignored", d, arr(adr(2'd1)));

    done_run();
  end
endmodule